// File: doc/BRIEF.md
# Prioritized Interrupt Controller, 64 Sources

The controller takes up to 64 level-sensitive interrupt lines. It decides which one the processor should service and presents that decision as a priority level and an 8-bit vector number. Each source has the following state:

- a pending bit, which copies the input line;
- a software force bit;
- a mask bit;
- a byte-wide priority level.

A level of zero turns the source off.

Software reaches all of this through a small byte-addressed register window. The mask and force bits are accessed as two 32-bit halves. Two byte commands mask or unmask one source by index, or all sources at once. A software-acknowledge read returns the vector currently presented. The level and vector outputs are registered, so they follow any change one clock later.

Top module: `prio_intc`

## Requirements
- R1: A source is active when it is enabled, its mask bit is 0, and its pending bit or its force bit is 1.
- R2: A source is enabled exactly when its level register is nonzero; writing 0 to it disables the source even if it is pending or forced.
- R3: Among active sources the one with the largest level wins; when levels are equal the higher source index wins.
- R4: `irq_vector` is 64 plus the winning index and `irq_level` is the winner's level; with no active source `irq_vector` is 24 and `irq_level` is 0.
- R5: Registers, all 32-bit reads on `rdata`:
  - 0x00 / 0x04: pending bits for sources 63..32 / 31..0. These are read-only and writes to them have no effect.
  - 0x08 / 0x0C: mask bits for sources 63..32 / 31..0, read/write.
  - 0x10 / 0x14: force bits for sources 63..32 / 31..0, read/write.
  - 0x40+n: level of source n, taken from `wdata[7:0]`.
  - Unmapped offsets read 0.
- R6: Writing to 0x1C sets the mask bit of source `wdata[5:0]`; if `wdata[6]` is 1, all mask bits are set instead.
- R7: Writing to 0x1D clears the mask bit of source `wdata[5:0]`; if `wdata[6]` is 1, all mask bits are cleared instead.
- R8: Reading offset 0xE0 returns the presented vector in bits 7:0, with zeros above.
- R9: After reset:
  - all mask bits are 1;
  - the pending and force bits are 0;
  - every level register is 0;
  - `irq_vector` is 24 and `irq_level` is 0.
- R10: Pending bits capture `src_i` on every clock. The outputs are registered, so a register write or captured input change is visible on `irq_level`/`irq_vector` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_level | output | 8 | Priority level of the selected source, 0 when idle |
| irq_vector | output | 8 | Vector number of the selected source |

## Verification
The bench builds the block with the default NSRC of 64, so both 32-bit halves of every bit register are populated. At that size, index bit 5 of the mask commands and the whole 0x40–0x7F level window are live. Random level values are drawn from a small range so that ties between distant sources occur often, which exercises the higher-index tie rule across the half boundary.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [7:0]      irq_level,
  output logic [7:0]      irq_vector
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [7:0] IDLE_VEC = 8'd24;

  logic [NSRC-1:0] pend_q, mask_q, force_q, enab, act;
  logic [7:0]      lvl_q [NSRC];
  logic [63:0]     pend64, mask64, force64;
  logic [7:0]      best_l;
  logic [IW-1:0]   best_i;
  logic            found;
  logic            lvl_hit;

  assign pend64  = 64'(pend_q);
  assign mask64  = 64'(mask_q);
  assign force64 = 64'(force_q);
  assign lvl_hit = (addr[7:6] == 2'b01) && (int'(addr[5:0]) < NSRC);

  for (genvar g = 0; g < NSRC; g++) begin : g_en
    assign enab[g] = |lvl_q[g];
  end

  assign act = (pend_q | force_q) & enab & ~mask_q;

  always_comb begin
    best_l = '0;
    best_i = '0;
    found  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && lvl_q[i] >= best_l) begin
        best_l = lvl_q[i];
        best_i = IW'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      mask_q     <= '1;
      force_q    <= '0;
      irq_level  <= '0;
      irq_vector <= IDLE_VEC;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      pend_q     <= src_i;
      irq_level  <= found ? best_l : 8'd0;
      irq_vector <= found ? 8'(64 + int'(best_i)) : IDLE_VEC;
      if (wr_en) begin
        case (addr)
          8'h08: mask_q  <= NSRC'({wdata, mask64[31:0]});
          8'h0C: mask_q  <= NSRC'({mask64[63:32], wdata});
          8'h10: force_q <= NSRC'({wdata, force64[31:0]});
          8'h14: force_q <= NSRC'({force64[63:32], wdata});
          8'h1C: mask_q  <= wdata[6] ? '1 : (mask_q | NSRC'(64'd1 << wdata[5:0]));
          8'h1D: mask_q  <= wdata[6] ? '0 : (mask_q & ~NSRC'(64'd1 << wdata[5:0]));
          default: if (lvl_hit) lvl_q[IW'(addr[5:0])] <= wdata[7:0];
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      8'h00:   rdata = pend64[63:32];
      8'h04:   rdata = pend64[31:0];
      8'h08:   rdata = mask64[63:32];
      8'h0C:   rdata = mask64[31:0];
      8'h10:   rdata = force64[63:32];
      8'h14:   rdata = force64[31:0];
      8'hE0:   rdata = {24'd0, irq_vector};
      default: rdata = lvl_hit ? {24'd0, lvl_q[IW'(addr[5:0])]} : 32'd0;
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NSRC = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            wr_en,
  input logic [7:0]      addr,
  input logic [31:0]     wdata,
  input logic [7:0]      irq_level,
  input logic [7:0]      irq_vector,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] pend_q
);
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 8'd0 |-> irq_vector == 8'd24); // R4
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 8'd0 |-> (irq_vector >= 8'd64 && int'(irq_vector) < 64 + NSRC)); // R4
  AST_PEND_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_q == $past(src_i)); // R10
  AST_MASK_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1C && wdata[6]) |=> &mask_q); // R6
  AST_MASK_ALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1D && wdata[6]) |=> mask_q == '0); // R7
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_i = '0;
  logic        wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq_level, irq_vector;

  int nvec = 0, nbad = 0;
  logic [63:0] m_mask, m_force, m_src;
  logic [7:0]  m_lvl [64];

  prio_intc #(.NSRC(64)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_out();
    logic [7:0] bl = 0, bv = 8'd24;
    for (int i = 0; i < 64; i++)
      if ((m_src[i] | m_force[i]) && m_lvl[i] != 0 && !m_mask[i] && m_lvl[i] >= bl) begin
        bl = m_lvl[i]; bv = 8'(64 + i);
      end
    return {bl, bv};
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    logic [15:0] o = model_out();
    case (a)
      8'h00: return m_src[63:32];
      8'h04: return m_src[31:0];
      8'h08: return m_mask[63:32];
      8'h0C: return m_mask[31:0];
      8'h10: return m_force[63:32];
      8'h14: return m_force[31:0];
      8'hE0: return {24'd0, o[7:0]};
      default: return (a[7:6] == 2'b01) ? {24'd0, m_lvl[a[5:0]]} : 32'd0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    case (a)
      8'h08: m_mask[63:32] = d;
      8'h0C: m_mask[31:0] = d;
      8'h10: m_force[63:32] = d;
      8'h14: m_force[31:0] = d;
      8'h1C: m_mask = d[6] ? '1 : m_mask | (64'd1 << d[5:0]);
      8'h1D: m_mask = d[6] ? '0 : m_mask & ~(64'd1 << d[5:0]);
      default: if (a[7:6] == 2'b01) m_lvl[a[5:0]] = d[7:0];
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_src(input logic [63:0] s);
    @(negedge clk);
    src_i = s; m_src = s;
    @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    logic [15:0] o;
    @(negedge clk);
    o = model_out();
    chk({tag, " vector"}, {24'd0, irq_vector}, {24'd0, o[7:0]});
    chk({tag, " level"},  {24'd0, irq_level},  {24'd0, o[15:8]});
    addr = 8'hE0; #1;
    chk("R8 ack read", rdata, {24'd0, o[7:0]});
  endtask

  task automatic check_rd(input logic [7:0] a, input string tag);
    addr = a; #1;
    chk(tag, rdata, model_rd(a));
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = '1; m_force = '0; m_src = '0;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 vector", {24'd0, irq_vector}, 32'd24);
    chk("R9 level", {24'd0, irq_level}, 32'd0);
    check_rd(8'h08, "R9 mask hi");
    check_rd(8'h0C, "R9 mask lo");
    check_rd(8'h14, "R9 force lo");
    check_rd(8'h7F, "R9 level 63");

    // R2: forced and unmasked but level 0 stays idle
    wr(8'h1D, 32'h40);
    wr(8'h14, 32'h0000_0001);
    check_out("R2 level zero disabled");
    // R3 tie: sources 5 and 40 at level 3, higher index wins
    wr(8'h45, 32'd3);
    wr(8'h68, 32'd3);
    wr(8'h10, 32'h0000_0100);
    wr(8'h14, 32'h0000_0020);
    check_out("R3 tie");
    chk("R3 tie vector", {24'd0, irq_vector}, 32'd104);
    // R3 larger level wins over higher index
    wr(8'h45, 32'd9);
    check_out("R3 larger level");
    chk("R3 larger vector", {24'd0, irq_vector}, 32'd69);
    // R6 single mask of source 5
    wr(8'h1C, 32'd5);
    check_out("R6 single mask");
    check_rd(8'h0C, "R6 mask lo");
    // R2 disable by writing 0
    wr(8'h68, 32'd0);
    check_out("R2 disable");
    // R6 all / R7 all
    wr(8'h1C, 32'h40);
    check_out("R6 mask all");
    check_rd(8'h08, "R6 mask hi all");
    wr(8'h1D, 32'h45);
    check_out("R7 clear all");
    check_rd(8'h0C, "R7 mask lo all");
    // R10 / R1 pending via input, R5 pending write ignored
    wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h7E, 32'd7);
    set_src(64'h4000_0000_0000_0000);
    check_out("R10 pending path");
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    check_rd(8'h00, "R5 pending write ignored hi");
    check_rd(8'h04, "R5 pending write ignored lo");
    check_rd(8'h30, "R5 unmapped");

    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 7);
      logic [7:0] a;
      case (op)
        0: set_src({$urandom, $urandom});
        1: wr($urandom_range(0, 1) ? 8'h08 : 8'h0C, $urandom);
        2: wr($urandom_range(0, 1) ? 8'h10 : 8'h14, $urandom & $urandom);
        3, 4: wr(8'h40 + 8'($urandom_range(0, 63)), 32'($urandom_range(0, 4)));
        5: wr(8'h1C, ($urandom_range(0, 15) == 0) ? 32'h40 : 32'($urandom_range(0, 63)));
        6: wr(8'h1D, ($urandom_range(0, 7) == 0) ? 32'h40 : 32'($urandom_range(0, 63)));
        default: wr($urandom_range(0, 1) ? 8'h00 : 8'h04, $urandom);
      endcase
      check_out("R1 R3 R4 random");
      a = ($urandom_range(0, 1) != 0) ? 8'(4 * $urandom_range(0, 5))
                                      : 8'h40 + 8'($urandom_range(0, 63));
      check_rd(a, "R5 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule